// File: doc/BRIEF.md
# Lane-Offset Xorshift Random Generator

This block produces 32-bit pseudo-random numbers from one shared state register. A requester presents a lane identifier and a range. The block adds the lane identifier to the current state and scrambles the sum with a fixed three-step shift-xor mix. The mixed word becomes the new state in the cycle the request is accepted. The requester then receives the mixed word reduced modulo its range.

The reduction uses an iterative remainder unit that retires one bit per cycle. While that unit is working, `req_ready` is low and requests are ignored. A seed port writes the state register directly. When a seed load and a request arrive in the same cycle, the seed load wins. A range of zero skips the reduction: the raw mixed word comes back on the next cycle with an error flag.

Top module: `xs_lane_rng`

## Requirements
- R1: After reset, `req_ready` is 1, `out_valid` is 0, and the state holds the parameter `RESET_SEED` (default 1). The first request therefore returns mix(RESET_SEED + lane).
- R2: When `seed_load` is 1 on a clock edge, the state takes `seed_value` directly, with no mixing.
- R3: The pre-mix word is the state plus the zero-extended lane identifier, wrapping modulo 2^32.
- R4: The mix is computed from the pre-mix word p. First t = p ^ (p << 11). The result is p ^ (p >> 19) ^ t ^ (t >> 8). All shifts are logical.
- R5: The mix result is written back as the new state, so successive requests chain from one another.
- R6: For a nonzero range, `out_value` is the mix result modulo the range and `out_err` is 0. Edge cases: a range of 1 gives 0, and a range larger than the result gives the result unchanged.
- R7: A range of 0 returns the unreduced mix result with `out_err` = 1. It appears on the clock edge after the one that accepts the request.
- R8: A seed load and a request in the same cycle load the seed. The request is dropped: no output pulse follows, and the state is not mixed.
- R9: Each accepted request yields exactly one `out_valid` pulse, one cycle wide.
- R10: While `req_ready` is 0, a request leaves the state unchanged and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Write `seed_value` into the state |
| seed_value | input | 32 | Seed word |
| req_valid | input | 1 | Generate request |
| req_lane | input | LANE_W | Lane identifier added to the state |
| req_range | input | 32 | Modulus for the output; 0 means no reduction |
| req_ready | output | 1 | High when a request can be accepted |
| out_valid | output | 1 | One-cycle pulse with a result |
| out_value | output | 32 | Reduced (or raw) random value |
| out_err | output | 1 | Set with `out_valid` when the range was 0 |

## Verification
The seed load and the generate request are the two functions that can land in the same cycle. The bench drives `seed_load` and `req_valid` on the same falling edge while the block is ready. It then watches for 40 cycles and expects no output pulse. Finally it issues a plain request and compares the result with mix(seed + lane), which proves the seed was loaded and the dropped request did not advance the state.

// File: rtl/xs_rng_pkg.sv
// Package: widths and shift amounts shared by the generator blocks.
// Assumes the data width is larger than every shift amount.
package xs_rng_pkg;
    localparam int DATA_W  = 32;
    localparam int SHL_A   = 11;
    localparam int SHR_B   = 19;
    localparam int SHR_C   = 8;
endpackage

// File: rtl/xs_mix.sv
// Combinational mixer: adds a lane offset to the state and applies the
// three-shift xor scramble. Assumes W > each shift amount.
module xs_mix
    import xs_rng_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int LANE_W = 8
) (
    input  logic [W-1:0]      state_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [W-1:0]      mix_o
);
    logic [W-1:0] pre;
    logic [W-1:0] tmp;

    // Offset the state by the lane, then scramble it.
    always_comb begin
        pre   = state_i + W'(lane_i);
        tmp   = pre ^ (pre << SHL_A);
        mix_o = pre ^ (pre >> SHR_B) ^ tmp ^ (tmp >> SHR_C);
    end
endmodule

// File: rtl/xs_moddiv.sv
// Iterative remainder unit: one quotient bit per cycle, W cycles per
// operation. Assumes divisor is nonzero and start only arrives when idle.
module xs_moddiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] rem_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, dq_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       trial;
    logic [W-1:0]     rem_next;

    // Shift the next dividend bit in and conditionally subtract.
    always_comb begin
        trial    = {rem_q, dq_q[W-1]};
        rem_next = (trial >= {1'b0, den_q}) ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
    end

    // Sequence the iterations and emit a one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dq_q   <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q  <= '0;
                dq_q   <= dividend_i;
                den_q  <= divisor_i;
                cnt_q  <= CNT_W'(W);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem_q <= rem_next;
                dq_q  <= dq_q << 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign rem_o = rem_q;

    // R10: the top must never start a new operation while one is running.
    a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R6: a finished remainder is always below the divisor.
    a_r6_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < den_q));
endmodule

// File: rtl/xs_lane_rng.sv
// Top: shared-state random generator. Seed load has priority over a
// request; nonzero ranges go through the iterative remainder unit,
// a zero range returns the raw word next cycle with an error flag.
module xs_lane_rng
    import xs_rng_pkg::*;
#(
    parameter int          LANE_W     = 8,
    parameter logic [31:0] RESET_SEED = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [31:0]       seed_value,
    input  logic              req_valid,
    input  logic [LANE_W-1:0] req_lane,
    input  logic [31:0]       req_range,
    output logic              req_ready,
    output logic              out_valid,
    output logic [31:0]       out_value,
    output logic              out_err
);
    localparam int W = DATA_W;

    logic [W-1:0] state_q, mixed, div_rem, raw_q;
    logic         accept, div_start, div_busy, div_done, raw_v_q;

    xs_mix #(.W(W), .LANE_W(LANE_W)) u_mix (
        .state_i (state_q),
        .lane_i  (req_lane),
        .mix_o   (mixed)
    );

    xs_moddiv #(.W(W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (mixed),
        .divisor_i  (req_range),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .rem_o      (div_rem)
    );

    // Accept a request only when idle and no seed load competes.
    always_comb begin
        req_ready = !div_busy;
        accept    = req_valid && req_ready && !seed_load;
        div_start = accept && (req_range != '0);
    end

    // Update the shared state: seed first, then accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RESET_SEED;
        else if (seed_load)
            state_q <= seed_value;
        else if (accept)
            state_q <= mixed;
    end

    // Register the raw word for zero-range requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_v_q <= 1'b0;
            raw_q   <= '0;
        end else begin
            raw_v_q <= accept && (req_range == '0);
            if (accept) raw_q <= mixed;
        end
    end

    // Merge the two result paths onto the output.
    always_comb begin
        out_valid = raw_v_q | div_done;
        out_value = raw_v_q ? raw_q : div_rem;
        out_err   = raw_v_q;
    end

    // R2: a seed load lands in the state on the next cycle.
    a_r2_seed_write: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (state_q == $past(seed_value)));

    // R8: a colliding request yields no result pulse.
    a_r8_seed_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && req_valid && req_ready) |=> !out_valid);

    // R7: the error flag only ever accompanies a result.
    a_r7_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
endmodule

// File: tb/xs_lane_rng_tb.sv
// Directed bench for xs_lane_rng: one task per scenario, each checking
// its own results against an independent model of the requirements.
module xs_lane_rng_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_lane = '0;
    logic [31:0] req_range = '0;
    logic        req_ready, out_valid, out_err;
    logic [31:0] out_value;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_state;

    always #10 clk = ~clk;

    xs_lane_rng u_dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
        .req_valid(req_valid), .req_lane(req_lane), .req_range(req_range),
        .req_ready(req_ready), .out_valid(out_valid), .out_value(out_value),
        .out_err(out_err)
    );

    function automatic logic [31:0] scramble(input logic [31:0] p);
        logic [31:0] t;
        t = p ^ (p << 11);
        return p ^ (p >> 19) ^ t ^ (t >> 8);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and check the value, error flag and pulse width.
    task automatic gen(input string tag, input logic [7:0] lane, input logic [31:0] rng);
        logic [31:0] res, exp;
        int waited;
        res = scramble(model_state + 32'(lane));
        model_state = res;
        exp = (rng == 0) ? res : res % rng;
        @(negedge clk);
        check({tag, " ready"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_lane = lane; req_range = rng;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!out_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check({tag, " valid"}, 32'(out_valid), 32'd1);
        check({tag, " value"}, out_value, exp);
        check({tag, " err"}, 32'(out_err), (rng == 0) ? 32'd1 : 32'd0);
        if (rng == 0) check("R7 latency", 32'(waited), 32'd0);
        @(negedge clk);
        check("R9 pulse width", 32'(out_valid), 32'd0);
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk);
        seed_load = 1'b1; seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        model_state = s;
    endtask

    task automatic t_reset;
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
        model_state = 32'h1;
        gen("R1 first from reset seed", 8'd0, 32'd0);
    endtask

    task automatic t_seed_and_wrap;
        load_seed(32'hFFFF_FFFF);
        gen("R3 lane wrap", 8'd3, 32'd0);
        load_seed(32'h1234_5678);
        gen("R2 R4 seeded mix", 8'd0, 32'd0);
    endtask

    task automatic t_chain;
        load_seed(32'hDEAD_BEEF);
        gen("R5 chain 1", 8'd7, 32'd1000);
        gen("R5 chain 2", 8'd200, 32'd97);
        gen("R5 chain 3", 8'd255, 32'd0);
    endtask

    task automatic t_ranges;
        load_seed(32'h0BAD_F00D);
        gen("R6 range one", 8'd1, 32'd1);
        gen("R6 range max", 8'd2, 32'hFFFF_FFFF);
        gen("R6 range pow2", 8'd9, 32'd64);
    endtask

    task automatic t_collide;
        int seen;
        @(negedge clk);
        seed_load = 1'b1; seed_value = 32'hCAFE_0001;
        req_valid = 1'b1; req_lane = 8'd5; req_range = 32'd0;
        @(negedge clk);
        seed_load = 1'b0; req_valid = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        check("R8 no pulse on collision", 32'(seen), 32'd0);
        model_state = 32'hCAFE_0001;
        gen("R8 seed kept", 8'd5, 32'd0);
    endtask

    task automatic t_busy;
        logic [31:0] res;
        int pulses;
        res = scramble(model_state + 32'd4);
        @(negedge clk);
        req_valid = 1'b1; req_lane = 8'd4; req_range = 32'd12345;
        @(negedge clk);
        req_lane = 8'd99; req_range = 32'd0;
        check("R10 ready low while busy", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            if (out_valid) begin
                pulses++;
                check("R10 busy result", out_value, res % 32'd12345);
            end
            @(negedge clk);
        end
        check("R10 single pulse", 32'(pulses), 32'd1);
        model_state = res;
        gen("R10 state not advanced", 8'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seed_and_wrap();
        t_chain();
        t_ranges();
        t_collide();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule